// File: doc/BRIEF.md
# Compact Instruction Expander

This block sits between instruction fetch and decode. It takes one 16-bit compact instruction word and produces the 32-bit RV64 base instruction that does the same work. It also raises a flag when the word is not a defined encoding, and a separate flag for the reserved all-zero word, which must trap. Decode therefore only ever sees full-width instructions.

The compact format selects an instruction group with the low four bits of the word. Several groups use a four-bit register field, which covers the registers x8 through x23. Other groups use a five-bit field split across the word, which reaches every register. The result is registered. Each accepted input word produces exactly one output word one clock cycle later.

Top module: `cinstr_expander`

## Requirements
- R1: A synchronous reset clears `out_valid`, `out_illegal`, `out_trap` and `out_instr`.
- R2: On every clock `out_valid` takes the value `in_valid` had one cycle earlier. The instruction and both flags load only when `in_valid` is high; otherwise they hold.
- R3: Low nibble 0000 is the five-bit-register group.
  - The register is {w[12],w[11:8]} and the value is the signed field {w[13],w[7:4]}.
  - w[15:14] selects the operation: 00 gives ADDI r,r,imm; 01 gives ADDI r,x0,imm; 10 gives ADD r,r,s; 11 gives ADD r,x0,s. Here s is the register whose number is that same field.
- R4: The word 0x0000 sets `out_trap`, leaves `out_illegal` low and outputs an all-zero instruction. A nonzero word in the same group, such as 0x0010, expands normally.
- R5: Low nibble 0100 is the four-bit-register ALU group.
  - The destination is 8+w[11:8] and the source is 8+w[7:4].
  - w[15:12] selects: 0000 ADDIW d,d,w[7:4] (unsigned); 0001 SUB d,d,s; 0100 ADDW d,d,s; 0101 AND; 0110 OR; 0111 XOR.
- R6: In the same group, code 0010 gives ADDIW d,d,−(w[7:4]+1), and code 0011 gives ADDIW d,s,0.
- R7: Low nibbles 0001 and 0101 are loads and stores.
  - The data register is 8+w[11:8] and the base register is 8+w[7:4].
  - The displacement is w[14:12]. With w[15]=0 it is scaled by 4 (LW/SW); with w[15]=1 it is scaled by 8 (LD/SD).
- R8: Low nibble 1001 is the stack-relative integer group, with x2 as the base.
  - The register is {w[12],w[11:8]} and the unsigned displacement is {w[13],w[7:4]}.
  - w[15:14] selects 00 LW (×4), 01 LD (×8), 10 SW (×4) or 11 SD (×8).
- R9: Low nibble 1101 with w[15:14]=00 gives JAL x0. Its offset is the signed value w[13:4] times 2.
- R10: Low nibble 1101 with w[15:14] = 01 or 11 gives FLD or FSD. The register is {w[12],w[11:8]}, the base is x2 and the offset is {w[13],w[7:4]}×8. With w[15:14]=10 it gives LUI, whose 20-bit upper field is the sign-extended {w[13],w[7:4]}.
- R11: Any low nibble other than 0000, 0001, 0100, 0101, 1001 or 1101 sets `out_illegal` and outputs all zeros.
- R12: In the 0100 group, codes 1000 through 1111 set `out_illegal` and output all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_word | input | 16 | Compact instruction word |
| out_valid | output | 1 | Registered result is present |
| out_instr | output | 32 | Expanded 32-bit instruction |
| out_illegal | output | 1 | Input was an undefined encoding |
| out_trap | output | 1 | Input was the reserved all-zero word |

## Verification
Every result of this block, whether the expanded instruction, either flag or `out_valid`, is due on the first rising edge after the input edge and at no other time. The bench therefore presents each word on a falling edge and reads all outputs at the next falling edge, after exactly one rising edge. The hold test drops `in_valid` for a single cycle and reads at the same point. This shows that `out_valid` falls while the instruction keeps its earlier value.

// File: rtl/cinstr_expander.sv
module cinstr_expander #(
  parameter int SP_REG   = 2,
  parameter int REG4_BASE = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_word,
  output logic        out_valid,
  output logic [31:0] out_instr,
  output logic        out_illegal,
  output logic        out_trap
);
  localparam logic [6:0] OP_LOAD   = 7'b0000011;
  localparam logic [6:0] OP_FLOAD  = 7'b0000111;
  localparam logic [6:0] OP_IMM    = 7'b0010011;
  localparam logic [6:0] OP_IMMW   = 7'b0011011;
  localparam logic [6:0] OP_STORE  = 7'b0100011;
  localparam logic [6:0] OP_FSTORE = 7'b0100111;
  localparam logic [6:0] OP_REG    = 7'b0110011;
  localparam logic [6:0] OP_LUI    = 7'b0110111;
  localparam logic [6:0] OP_REGW   = 7'b0111011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [4:0] SPR       = 5'(SP_REG);
  localparam logic [4:0] RB4       = 5'(REG4_BASE);

  function automatic logic [31:0] fi(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3,
                                     logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fr(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] fs(logic [11:0] imm, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  logic [15:0] w;
  logic [4:0]  r5, i5, ra4, rb4;
  logic [11:0] simm, lsoff, spoff, fpoff;
  logic [20:0] joff;
  logic [31:0] ins;
  logic        ill, trp;

  assign w     = in_word;
  assign r5    = {w[12], w[11:8]};
  assign i5    = {w[13], w[7:4]};
  assign ra4   = RB4 + {1'b0, w[11:8]};
  assign rb4   = RB4 + {1'b0, w[7:4]};
  assign simm  = {{7{i5[4]}}, i5};
  assign lsoff = w[15] ? {6'b0, w[14:12], 3'b0} : {7'b0, w[14:12], 2'b0};
  assign spoff = w[14] ? {4'b0, i5, 3'b0} : {5'b0, i5, 2'b0};
  assign fpoff = {4'b0, i5, 3'b0};
  assign joff  = {{10{w[13]}}, w[13:4], 1'b0};

  always_comb begin
    ins = 32'h0;
    ill = 1'b0;
    trp = 1'b0;
    unique case (w[3:0])
      4'b0000: begin
        if (w == 16'h0000) trp = 1'b1;
        else begin
          unique case (w[15:14])
            2'b00: ins = fi(simm, r5, 3'b000, r5, OP_IMM);
            2'b01: ins = fi(simm, 5'd0, 3'b000, r5, OP_IMM);
            2'b10: ins = fr(7'h00, i5, r5, 3'b000, r5, OP_REG);
            default: ins = fr(7'h00, i5, 5'd0, 3'b000, r5, OP_REG);
          endcase
        end
      end
      4'b0100: begin
        unique case (w[15:12])
          4'h0: ins = fi({8'h00, w[7:4]}, ra4, 3'b000, ra4, OP_IMMW);
          4'h1: ins = fr(7'h20, rb4, ra4, 3'b000, ra4, OP_REG);
          4'h2: ins = fi({8'hFF, ~w[7:4]}, ra4, 3'b000, ra4, OP_IMMW);
          4'h3: ins = fi(12'h000, rb4, 3'b000, ra4, OP_IMMW);
          4'h4: ins = fr(7'h00, rb4, ra4, 3'b000, ra4, OP_REGW);
          4'h5: ins = fr(7'h00, rb4, ra4, 3'b111, ra4, OP_REG);
          4'h6: ins = fr(7'h00, rb4, ra4, 3'b110, ra4, OP_REG);
          4'h7: ins = fr(7'h00, rb4, ra4, 3'b100, ra4, OP_REG);
          default: ill = 1'b1;
        endcase
      end
      4'b0001: ins = fi(lsoff, rb4, {2'b01, w[15]}, ra4, OP_LOAD);
      4'b0101: ins = fs(lsoff, ra4, rb4, {2'b01, w[15]}, OP_STORE);
      4'b1001: ins = w[15] ? fs(spoff, r5, SPR, {2'b01, w[14]}, OP_STORE)
                           : fi(spoff, SPR, {2'b01, w[14]}, r5, OP_LOAD);
      4'b1101: begin
        unique case (w[15:14])
          2'b00: ins = {joff[20], joff[10:1], joff[11], joff[19:12], 5'd0, OP_JAL};
          2'b01: ins = fi(fpoff, SPR, 3'b011, r5, OP_FLOAD);
          2'b10: ins = {{15{i5[4]}}, i5, r5, OP_LUI};
          default: ins = fs(fpoff, r5, SPR, 3'b011, OP_FSTORE);
        endcase
      end
      default: ill = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_instr   <= 32'h0;
      out_illegal <= 1'b0;
      out_trap    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_instr   <= ins;
        out_illegal <= ill;
        out_trap    <= trp;
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> out_valid == $past(in_valid));

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(in_valid)) |-> ($stable(out_instr) && $stable(out_illegal) && $stable(out_trap)));

  // R4
  trap_clean_chk: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> (out_instr == 32'h0 && !out_illegal));

  // R11
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> out_instr == 32'h0);

  // R3
  full_width_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && !out_trap) |-> out_instr[1:0] == 2'b11);
endmodule

// File: tb/cinstr_expander_tb.sv
module cinstr_expander_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = 16'h0;
  logic        out_valid, out_illegal, out_trap;
  logic [31:0] out_instr;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cinstr_expander u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_instr(out_instr),
    .out_illegal(out_illegal), .out_trap(out_trap)
  );

  function automatic logic [31:0] enc_i(int imm, int rs1, int f3, int rd, int op);
    return {imm[11:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] enc_r(int f7, int rs2, int rs1, int f3, int rd, int op);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] enc_s(int imm, int rs2, int rs1, int f3, int op);
    return {imm[11:5], rs2[4:0], rs1[4:0], f3[2:0], imm[4:0], op[6:0]};
  endfunction
  function automatic logic [31:0] enc_j(int imm, int rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd[4:0], 7'h6F};
  endfunction
  function automatic logic [31:0] enc_u(int imm20, int rd, int op);
    return {imm20[19:0], rd[4:0], op[6:0]};
  endfunction

  localparam int NV = 34;
  // {word, expected instruction, illegal, trap}
  localparam logic [49:0] VEC [NV] = '{
    {16'h2DD0, enc_i(-3, 13, 0, 13, 7'h13), 2'b00},        // R3 addi
    {16'h5470, enc_i(7, 0, 0, 20, 7'h13), 2'b00},          // R3 li
    {16'hA1F0, enc_r(0, 31, 1, 0, 1, 7'h33), 2'b00},       // R3 add
    {16'hD160, enc_r(0, 6, 0, 0, 17, 7'h33), 2'b00},       // R3 mv
    {16'h0010, enc_i(1, 0, 0, 0, 7'h13), 2'b00},           // R4 nonzero no trap
    {16'h03F4, enc_i(15, 11, 0, 11, 7'h1B), 2'b00},        // R5 addiw
    {16'h10F4, enc_r(7'h20, 23, 8, 0, 8, 7'h33), 2'b00},   // R5 sub
    {16'h2504, enc_i(-1, 13, 0, 13, 7'h1B), 2'b00},        // R6 neg
    {16'h2AF4, enc_i(-16, 18, 0, 18, 7'h1B), 2'b00},       // R6 neg min
    {16'h3124, enc_i(0, 10, 0, 9, 7'h1B), 2'b00},          // R6 mvw
    {16'h47E4, enc_r(0, 22, 15, 0, 15, 7'h3B), 2'b00},     // R5 addw
    {16'h5234, enc_r(0, 11, 10, 7, 10, 7'h33), 2'b00},     // R5 and
    {16'h6234, enc_r(0, 11, 10, 6, 10, 7'h33), 2'b00},     // R5 or
    {16'h7234, enc_r(0, 11, 10, 4, 10, 7'h33), 2'b00},     // R5 xor
    {16'h8234, 32'h0, 2'b10},                              // R12
    {16'hF234, 32'h0, 2'b10},                              // R12
    {16'h5241, enc_i(20, 12, 2, 10, 7'h03), 2'b00},        // R7 lw
    {16'hFF01, enc_i(56, 8, 3, 23, 7'h03), 2'b00},         // R7 ld
    {16'h1195, enc_s(4, 9, 17, 2, 7'h23), 2'b00},          // R7 sw
    {16'hE0F5, enc_s(48, 8, 23, 3, 7'h23), 2'b00},         // R7 sd
    {16'h25F9, enc_i(124, 2, 2, 5, 7'h03), 2'b00},         // R8 lw sp
    {16'h7209, enc_i(128, 2, 3, 18, 7'h03), 2'b00},        // R8 ld sp
    {16'h8129, enc_s(8, 1, 2, 2, 7'h23), 2'b00},           // R8 sw sp
    {16'hFFF9, enc_s(248, 31, 2, 3, 7'h23), 2'b00},        // R8 sd sp
    {16'h005D, enc_j(10, 0), 2'b00},                       // R9 fwd
    {16'h3FFD, enc_j(-2, 0), 2'b00},                       // R9 back
    {16'h200D, enc_j(-1024, 0), 2'b00},                    // R9 min
    {16'h433D, enc_i(24, 2, 3, 3, 7'h07), 2'b00},          // R10 fld
    {16'hAA0D, enc_u(32'hFFFF0, 10, 7'h37), 2'b00},        // R10 lui neg
    {16'h83FD, enc_u(32'h0000F, 3, 7'h37), 2'b00},         // R10 lui pos
    {16'hD01D, enc_s(8, 16, 2, 3, 7'h27), 2'b00},          // R10 fsd
    {16'h1232, 32'h0, 2'b10},                              // R11
    {16'hABCF, 32'h0, 2'b10},                              // R11
    {16'h0008, 32'h0, 2'b10}                               // R11
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] wd);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = wd;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, out_valid}, 32'h0);
    check("R1 flags", {30'b0, out_illegal, out_trap}, 32'h0);
    check("R1 instr", out_instr, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][49:34]);
      check("R2 valid", {31'b0, out_valid}, 32'h1);
      check($sformatf("R3-R12 vec %0d instr", i), out_instr, VEC[i][33:2]);
      check($sformatf("R4 R11 R12 vec %0d flags", i), {30'b0, out_illegal, out_trap},
            {30'b0, VEC[i][1:0]});
    end

    // R4 reserved zero word
    apply(16'h0000);
    check("R4 trap", {30'b0, out_illegal, out_trap}, 32'h1);
    check("R4 instr", out_instr, 32'h0);

    // R2 hold while idle
    apply(16'h5470);
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = 16'h1232;
    @(negedge clk);
    check("R2 idle valid", {31'b0, out_valid}, 32'h0);
    check("R2 idle instr", out_instr, enc_i(7, 0, 0, 20, 7'h13));
    check("R2 idle flags", {30'b0, out_illegal, out_trap}, 32'h0);

    // R1 reset mid-run after an illegal word
    apply(16'hABCF);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid valid", {31'b0, out_valid}, 32'h0);
    check("R1 mid flags", {30'b0, out_illegal, out_trap}, 32'h0);
    check("R1 mid instr", out_instr, 32'h0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule